// File: doc/BRIEF.md
# LED activity pulse stretcher

This block turns brief link or traffic events into a light that a person can see. A raw event input, high for as little as one clock, goes in. One LED drive bit comes out. The block has three operating modes, and a small state machine chooses among them from three control inputs.

Stretching is switched on by either of two sources, a board pin or a register bit, which are ORed. When stretching is on, each event keeps the LED lit for a minimum time of 42 ms, and the clock frequency parameter sets how many cycles that is. When both stretch sources are low, the LED repeats the event with one clock of delay. Blink mode has priority over both. In blink mode the LED toggles with a fixed half-period while there has been recent activity, and it is dark when there has been none.

The states are DARK (LED off), MIRROR (lit in direct mode), HOLD (lit by the stretch timer), BLINK_ON and BLINK_OFF. The transitions are as follows:
- any state → MIRROR or DARK in direct mode, depending on the event;
- any state → HOLD on an event in stretch mode;
- HOLD → DARK when the hold timer expires with no new event;
- DARK, MIRROR or HOLD → BLINK_ON when blink mode sees activity;
- BLINK_ON ↔ BLINK_OFF when the phase timer expires;
- any blink state → DARK when the activity window is empty.

Top module: `led_pulse_stretcher`

## Requirements
- R1: Reset, which is asynchronous and active low, forces the LED off and clears all timers. After reset, the LED stays off until a new event arrives.
- R2: Stretch mode is in effect when `strch_pin_i` is high, when `strch_reg_i` is high, or when both are high. Either source alone is enough.
- R3: In stretch mode, an event sampled at a clock edge lights the LED from that edge for exactly HOLD_CYC cycles. HOLD_CYC is (CLK_HZ/1000)·HOLD_MS, and HOLD_MS defaults to 42. The LED then goes dark unless another event has arrived.
- R4: In stretch mode, an event that arrives while the LED is already held restarts the full HOLD_CYC interval from that event.
- R5: When both stretch sources are low and blink is off, the LED after each clock edge equals the event value sampled at that edge.
- R6: When `blink_en_i` is high, no minimum hold is applied, even if a stretch source is high.
- R7: In blink mode, one single-cycle event sampled at edge k gives the following pattern: lit for BLINK_HALF cycles, dark for BLINK_HALF cycles, then dark. BLINK_HALF is (CLK_HZ/1000)·BLINK_HALF_MS.
- R8: In blink mode, an event input held high makes the LED toggle every BLINK_HALF cycles, starting lit.
- R9: In blink mode, when no event has been seen in the last 2·BLINK_HALF cycles, the LED is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Raw link or activity event |
| strch_pin_i | input | 1 | Stretch enable from a pin |
| strch_reg_i | input | 1 | Stretch enable from a register bit |
| blink_en_i | input | 1 | Blink mode select (has priority) |
| led_o | output | 1 | LED drive, high means lit |

## Verification
Stretching is driven from each enable source alone and from both together. This shows that the enable is a true OR, and that the exact lit length equals the derived hold count. A second event in the middle of a hold shows restart as distinct from a fixed one-shot. A mixed 0/1 event sequence in direct mode shows mirroring as distinct from any stretching. In blink mode, a lone pulse, a held event and silence tell apart the single-period pattern, continuous toggling and the dark idle state; because a stretch source is also high during the lone pulse, that case also shows that blink has priority.

// File: rtl/led_strch_pkg.sv
package led_strch_pkg;

    typedef enum logic [2:0] {
        S_DARK,
        S_MIRROR,
        S_HOLD,
        S_BLINK_ON,
        S_BLINK_OFF
    } led_state_e;

    typedef enum logic [1:0] {
        M_DIRECT,
        M_STRETCH,
        M_BLINK
    } led_mode_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/led_mode_decode.sv
module led_mode_decode
    import led_strch_pkg::*;
(
    input  logic      strch_pin_i,
    input  logic      strch_reg_i,
    input  logic      blink_en_i,
    output led_mode_e mode_o
);

    logic strch_any;

    always_comb begin
        strch_any = strch_pin_i | strch_reg_i;
        if (blink_en_i)
            mode_o = M_BLINK;
        else if (strch_any)
            mode_o = M_STRETCH;
        else
            mode_o = M_DIRECT;
    end

endmodule

// File: rtl/led_downcnt.sv
module led_downcnt #(
    parameter int unsigned W        = 8,
    parameter int unsigned LOAD_VAL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= W'(LOAD_VAL);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R3: an idle counter never wraps back to a nonzero count.
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> cnt_q == '0);

    // R4: a load request restarts the interval.
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !zero_o || (LOAD_VAL == 0));

endmodule

// File: rtl/led_pulse_stretcher.sv
module led_pulse_stretcher
    import led_strch_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned HOLD_MS       = 42,
    parameter int unsigned BLINK_HALF_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic strch_pin_i,
    input  logic strch_reg_i,
    input  logic blink_en_i,
    output logic led_o
);

    localparam int unsigned CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int unsigned HOLD_CYC   = CYC_PER_MS * HOLD_MS;
    localparam int unsigned HALF_CYC   = CYC_PER_MS * BLINK_HALF_MS;
    localparam int unsigned WIN_CYC    = 2 * HALF_CYC;
    localparam int unsigned HOLD_W     = cnt_width(HOLD_CYC);
    localparam int unsigned HALF_W     = cnt_width(HALF_CYC);
    localparam int unsigned WIN_W      = cnt_width(WIN_CYC);

    led_mode_e  mode;
    led_state_e state_q, state_d;
    logic       hold_ld, phase_ld;
    logic       hold_zero, phase_zero, win_zero;
    logic       active;

    led_mode_decode u_mode (
        .strch_pin_i (strch_pin_i),
        .strch_reg_i (strch_reg_i),
        .blink_en_i  (blink_en_i),
        .mode_o      (mode)
    );

    led_downcnt #(.W(HOLD_W), .LOAD_VAL(HOLD_CYC - 1)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (hold_ld),
        .zero_o (hold_zero)
    );

    led_downcnt #(.W(HALF_W), .LOAD_VAL(HALF_CYC - 1)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (phase_ld),
        .zero_o (phase_zero)
    );

    led_downcnt #(.W(WIN_W), .LOAD_VAL(WIN_CYC - 1)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (evt_i),
        .zero_o (win_zero)
    );

    assign active = evt_i | !win_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_DARK;
        else
            state_q <= state_d;
    end

    // Next state and timer control
    always_comb begin
        state_d  = S_DARK;
        hold_ld  = 1'b0;
        phase_ld = 1'b0;
        unique case (mode)
            M_BLINK: begin
                if (!active) begin
                    state_d = S_DARK;
                end else begin
                    unique case (state_q)
                        S_BLINK_ON: begin
                            if (phase_zero) begin
                                state_d  = S_BLINK_OFF;
                                phase_ld = 1'b1;
                            end else begin
                                state_d = S_BLINK_ON;
                            end
                        end
                        S_BLINK_OFF: begin
                            if (phase_zero) begin
                                state_d  = S_BLINK_ON;
                                phase_ld = 1'b1;
                            end else begin
                                state_d = S_BLINK_OFF;
                            end
                        end
                        default: begin
                            state_d  = S_BLINK_ON;
                            phase_ld = 1'b1;
                        end
                    endcase
                end
            end
            M_STRETCH: begin
                if (evt_i) begin
                    state_d = S_HOLD;
                    hold_ld = 1'b1;
                end else if (state_q == S_HOLD && !hold_zero) begin
                    state_d = S_HOLD;
                end else begin
                    state_d = S_DARK;
                end
            end
            default: begin
                state_d = evt_i ? S_MIRROR : S_DARK;
            end
        endcase
    end

    // Output decode
    always_comb begin
        led_o = (state_q == S_MIRROR) || (state_q == S_HOLD) || (state_q == S_BLINK_ON);
    end

    // R2: either stretch source alone turns an event into a held light.
    p_single_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((strch_pin_i ^ strch_reg_i) && !blink_en_i && evt_i) |=> led_o);

    // R3: an unexpired hold keeps the LED lit.
    p_hold_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && !hold_zero && !blink_en_i && (strch_pin_i | strch_reg_i)) |=> led_o);

    // R5: direct mode repeats the sampled event.
    p_direct_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!blink_en_i && !strch_pin_i && !strch_reg_i) |=> led_o == $past(evt_i));

    // R6: blink mode never enters the hold state.
    p_blink_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blink_en_i |=> state_q != S_HOLD);

    // R8: an expired phase in the lit half toggles to dark while active.
    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en_i && active && state_q == S_BLINK_ON && phase_zero) |=> !led_o);

    // R9: no activity in blink mode means a dark LED.
    p_blink_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en_i && !evt_i && win_zero) |=> !led_o);

endmodule

// File: tb/tb_led_pulse_stretcher.sv
module tb_led_pulse_stretcher;

    localparam int unsigned CLK_HZ   = 1000;
    localparam int unsigned HOLD_MS  = 42;
    localparam int unsigned HALF_MS  = 5;
    localparam int unsigned HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
    localparam int unsigned HALF_CYC = (CLK_HZ / 1000) * HALF_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_i = 1'b0;
    logic strch_pin_i = 1'b0;
    logic strch_reg_i = 1'b0;
    logic blink_en_i = 1'b0;
    logic led_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    led_pulse_stretcher #(
        .CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS), .BLINK_HALF_MS(HALF_MS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .strch_pin_i(strch_pin_i),
        .strch_reg_i(strch_reg_i), .blink_en_i(blink_en_i), .led_o(led_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: led_o actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Checks a run of cycles as one check; reports the first mismatch.
    task automatic check_run(input string tag, input int n, input logic exp);
        logic bad = 1'b0;
        logic seen = exp;
        for (int i = 0; i < n; i++) begin
            if (!bad && led_o !== exp) begin bad = 1'b1; seen = led_o; end
            @(negedge clk);
        end
        check(tag, seen, exp);
    endtask

    task automatic settle();
        evt_i = 0; strch_pin_i = 0; strch_reg_i = 0; blink_en_i = 0;
        repeat (HOLD_CYC + 4 * HALF_CYC + 4) @(negedge clk);
    endtask

    // Leaves the bench at the negedge following the capturing edge.
    task automatic pulse();
        evt_i = 1'b1;
        @(negedge clk);
        evt_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 after reset", led_o, 1'b0);
        strch_pin_i = 1;
        pulse();
        repeat (5) @(negedge clk);
        rst_n = 0;
        #1;
        check("R1 reset mid hold", led_o, 1'b0);
        @(negedge clk);
        rst_n = 1;
        check_run("R1 dark after reset release", HOLD_CYC + 2, 1'b0);
        settle();
    endtask

    task automatic t_stretch(input logic pin, input logic rg, input string tag);
        strch_pin_i = pin; strch_reg_i = rg;
        @(negedge clk);
        pulse();
        check_run({tag, " lit for HOLD_CYC"}, HOLD_CYC, 1'b1);
        check({tag, " dark after hold"}, led_o, 1'b0);
        settle();
    endtask

    task automatic t_retrigger();
        strch_reg_i = 1;
        @(negedge clk);
        pulse();
        repeat (19) @(negedge clk);
        pulse();
        check_run("R4 restarted hold lit", HOLD_CYC, 1'b1);
        check("R4 dark after restarted hold", led_o, 1'b0);
        settle();
    endtask

    task automatic t_direct();
        logic [9:0] pat = 10'b1011001110;
        logic prev = 1'b0;
        for (int i = 0; i < 10; i++) begin
            evt_i = pat[i];
            prev = pat[i];
            @(negedge clk);
            check("R5 mirror", led_o, prev);
        end
        evt_i = 0;
        @(negedge clk);
        check("R5 mirror final low", led_o, 1'b0);
        settle();
    endtask

    task automatic t_blink_single();
        blink_en_i = 1; strch_pin_i = 1;
        @(negedge clk);
        pulse();
        check_run("R7 blink lit half", HALF_CYC, 1'b1);
        check_run("R6 R7 blink dark half, no hold", HALF_CYC, 1'b0);
        check_run("R7 dark after one period", 20, 1'b0);
        settle();
    endtask

    task automatic t_blink_cont();
        blink_en_i = 1;
        @(negedge clk);
        evt_i = 1;
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            check_run("R8 toggle lit", HALF_CYC, 1'b1);
            check_run("R8 toggle dark", HALF_CYC, 1'b0);
        end
        settle();
    endtask

    task automatic t_blink_none();
        blink_en_i = 1;
        check_run("R9 blink idle dark", 30, 1'b0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_stretch(1'b1, 1'b0, "R2 R3 pin only");
        t_stretch(1'b0, 1'b1, "R2 R3 reg only");
        t_stretch(1'b1, 1'b1, "R2 R3 both");
        t_retrigger();
        t_direct();
        t_blink_single();
        t_blink_cont();
        t_blink_none();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule